// File: doc/BRIEF.md
# Page-Mode Burst Read Sequencer

This block drives an asynchronous pseudo-static RAM through a burst read of 4, 8 or 16 words using the device's page read mode. The host presents a start word address and a two-bit length code on a valid strobe. The sequencer then selects the device and keeps every address bit above the page offset constant. It allows the full random-access latency for the first word and, after that, changes only the offset bits and allows the shorter page latency for each further word.

The start address may lie anywhere inside its page. The offset counts up by one and wraps within the page, so a burst always returns exactly one page's worth of words and never crosses a page boundary. Each word leaves the block with a one-cycle valid flag, and the final word also carries a last flag. After the final word the device is deselected and held deselected for a configurable recovery time before the next request is taken. This keeps the chip-enable low time short and bounded, and both byte lanes stay enabled throughout. Writes, power-up sequencing and arbitration are handled elsewhere.

All latencies are given in clock cycles as parameters. They are sized by the integrator from the clock period against the device's 70 ns first-access time, its 25 ns page cycle and its read cycle time.

Top module: `psram_page_burst`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy` and `rd_valid` are low and `mem_ce_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are high. Reset is asynchronous and abandons any burst in flight.
- R2: The length code selects the burst length: 0 gives 4 words, 1 gives 8 words, and 2 or 3 give 16 words. A burst produces exactly that many `rd_valid` pulses. `rd_last` is high together with the final pulse and only then.
- R3: Throughout a burst, `mem_addr` bits above the page offset equal the requested address. The page offset is `req_addr[1:0]`, `[2:0]` or `[3:0]` for 4, 8 or 16 words. The offset starts at the requested value and steps by one modulo the page length after each word. The other bits of `mem_addr[3:0]` stay as requested.
- R4: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. The first word is captured on the FIRST_CYC-th edge after the acceptance edge, so `rd_valid` is first seen high in the cycle that follows that edge.
- R5: Each following word is captured PAGE_CYC edges after the previous one.
- R6: `rd_data` equals the value of `mem_dq_in` at the capture edge, which is the last edge of that word's access window.
- R7: `mem_ce_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are low from the acceptance edge until the last capture edge and high afterwards. `mem_we_n` is always high.
- R8: After the last capture edge the device stays deselected for at least GAP_CYC cycles. `req_valid` is ignored while `busy` is high, which covers the whole burst and the recovery gap.
- R9: The device is never selected for more than FIRST_CYC + 15*PAGE_CYC consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request strobe |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | 2 | Length code: 0=4, 1=8, 2/3=16 words |
| busy | output | 1 | Burst or recovery gap in progress; requests ignored |
| mem_addr | output | ADDR_W | Word address to the memory |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, held high |
| mem_ub_n | output | 1 | Upper byte lane enable, active low |
| mem_lb_n | output | 1 | Lower byte lane enable, active low |
| mem_dq_in | input | DATA_W | Read data from the memory |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | `rd_data` holds a new word this cycle |
| rd_last | output | 1 | Final word of the burst |

## Verification
With the acceptance edge counted as edge 0, word i of a burst is due on edge FIRST_CYC + i*PAGE_CYC. The device is deselected after the final word's edge, and `busy` falls GAP_CYC edges later. The bench counts falling edges from acceptance and samples each output half a cycle after the edge that should change it. At every falling edge in the burst it compares `rd_valid` against the computed schedule, so a word that arrives early or late is caught as well as one that carries the wrong value. The memory model in the bench returns a marker value until the address has been stable for the required number of cycles, so a shortened access window shows up as wrong data.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FIRST = 2'd1,
    S_PAGE  = 2'd2,
    S_GAP   = 2'd3
  } burst_state_e;

  // number of words fetched for a length code
  function automatic logic [4:0] page_words(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // address bits that are allowed to move inside a page
  function automatic logic [3:0] page_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 4'h3;
      2'd1:    return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

  // increment the page offset, wrapping inside the page
  function automatic logic [3:0] wrap_next(input logic [3:0] off, input logic [1:0] code);
    logic [3:0] m;
    m = page_mask(code);
    return (off & ~m) | ((off + 4'd1) & m);
  endfunction

endpackage

// File: rtl/psram_burst_timer.sv
module psram_burst_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/psram_burst_addr.sv
module psram_burst_addr
  import psram_burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [1:0]        load_len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= 2'd0;
    end else if (load) begin
      addr_q <= load_addr;
      len_q  <= load_len;
    end else if (step) begin
      addr_q[3:0] <= wrap_next(addr_q[3:0], len_q);
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/psram_page_burst.sv
module psram_page_burst
  import psram_burst_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int FIRST_CYC = 7,
  parameter int PAGE_CYC  = 3,
  parameter int GAP_CYC   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_last
);
  localparam int MAX_WIN = (FIRST_CYC > PAGE_CYC) ?
                           ((FIRST_CYC > GAP_CYC) ? FIRST_CYC : GAP_CYC) :
                           ((PAGE_CYC > GAP_CYC) ? PAGE_CYC : GAP_CYC);
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam int LOW_MAX = FIRST_CYC + 15 * PAGE_CYC;
  localparam int LOW_W   = $clog2(LOW_MAX + 2);
  localparam logic [CNT_W-1:0] LD_FIRST = CNT_W'(FIRST_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PAGE  = CNT_W'(PAGE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(GAP_CYC - 1);

  burst_state_e     state_q;
  logic [3:0]       words_left_q;
  logic [4:0]       req_words;
  logic             in_window;
  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  // named internal events
  logic accept;
  logic win_end;
  logic last_word;
  logic step;

  assign req_words = page_words(req_len);
  assign in_window = (state_q == S_FIRST) || (state_q == S_PAGE);
  assign accept    = (state_q == S_IDLE) && req_valid;
  assign win_end   = in_window && tmr_zero;
  assign last_word = win_end && (words_left_q == 4'd0);
  assign step      = win_end && !last_word;

  always_comb begin
    tmr_load = accept || win_end;
    if (accept)         tmr_val = LD_FIRST;
    else if (last_word) tmr_val = LD_GAP;
    else                tmr_val = LD_PAGE;
  end

  psram_burst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  psram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (req_addr),
    .load_len  (req_len),
    .step      (step),
    .addr      (mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      words_left_q <= 4'd0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          state_q      <= S_FIRST;
          words_left_q <= 4'(req_words - 5'd1);
        end
        S_FIRST, S_PAGE: if (win_end) begin
          if (last_word) state_q <= S_GAP;
          else begin
            state_q      <= S_PAGE;
            words_left_q <= words_left_q - 4'd1;
          end
        end
        S_GAP: if (tmr_zero) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // capture in the last cycle of each access window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= win_end;
      rd_last  <= last_word;
      if (win_end) rd_data <= mem_dq_in;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign mem_ce_n = !in_window;
  assign mem_oe_n = !in_window;
  assign mem_ub_n = !in_window;
  assign mem_lb_n = !in_window;
  assign mem_we_n = 1'b1;

  // observation counters for the assertions
  logic [LOW_W-1:0] ce_low_cnt;
  logic [CNT_W:0]   ce_high_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_low_cnt  <= '0;
      ce_high_cnt <= (CNT_W+1)'(GAP_CYC);
    end else begin
      ce_low_cnt  <= mem_ce_n ? '0 : ce_low_cnt + 1'b1;
      if (!mem_ce_n)                               ce_high_cnt <= '0;
      else if (ce_high_cnt < (CNT_W+1)'(GAP_CYC))  ce_high_cnt <= ce_high_cnt + 1'b1;
    end
  end

  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> (mem_addr[ADDR_W-1:4] == $past(mem_addr[ADDR_W-1:4])))
    else $error("upper address moved inside a burst");

  p_capture_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_ce_n && !mem_oe_n))
    else $error("word captured outside an access window");

  p_last_with_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid)
    else $error("last flag without a word");

  p_select_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_low_cnt <= LOW_W'(LOW_MAX))
    else $error("chip select held too long");

  p_recovery_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> ($past(ce_high_cnt) >= (CNT_W+1)'(GAP_CYC)))
    else $error("reselected before the recovery gap");

endmodule

// File: tb/tb_psram_page_burst.sv
module tb_psram_page_burst;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int F  = 7;
  localparam int P  = 3;
  localparam int G  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_len = 2'd0;
  logic busy, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, rd_valid, rd_last;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_in, rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_page_burst #(.ADDR_W(AW), .DATA_W(DW), .FIRST_CYC(F), .PAGE_CYC(P), .GAP_CYC(G)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_in(mem_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last)
  );

  // memory contents as a function of the word address
  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ {a[19:16], 12'h5A3};
  endfunction

  // memory model: data appears only after the address has been stable long enough
  logic [AW-1:0] prev_addr = '0;
  logic prev_ce_n = 1'b1;
  int age = 0;
  int need = F;
  always @(negedge clk) begin
    if (mem_ce_n) begin
      age <= 0; need <= F;
    end else if (prev_ce_n || prev_addr[AW-1:4] != mem_addr[AW-1:4]) begin
      age <= 1; need <= F;
    end else if (prev_addr != mem_addr) begin
      age <= 1; need <= P;
    end else if (age < 100000) begin
      age <= age + 1;
    end
    prev_addr <= mem_addr;
    prev_ce_n <= mem_ce_n;
  end
  always_comb begin
    if (!mem_ce_n && !mem_oe_n && age != 0 && age >= need) mem_dq_in = pat(mem_addr);
    else mem_dq_in = 16'hBAD0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL R8 watchdog expired actual %0d cycles expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one burst; with inject the request line is kept busy with junk during the burst and gap
  task automatic do_burst(input logic [AW-1:0] a, input logic [1:0] len, input logic inject);
    int n, last_k, vbad;
    logic [3:0] m;
    n = (len == 2'd0) ? 4 : (len == 2'd1) ? 8 : 16;
    m = (len == 2'd0) ? 4'h3 : (len == 2'd1) ? 4'h7 : 4'hF;
    last_k = F + (n - 1) * P;
    vbad = 0;
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = len;
    for (int k = 1; k <= last_k + G + 4; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (inject) begin req_addr = ~a; req_len = 2'd0; end
        else req_valid = 1'b0;
        check(mem_addr == a, "R3 start address", 32'(mem_addr), 32'(a));
        check(!mem_ce_n && !mem_oe_n && !mem_ub_n && !mem_lb_n && mem_we_n,
              "R7 select pins in burst",
              {27'd0, mem_ce_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_we_n}, 32'h1);
      end
      if (k == last_k + G + 1) req_valid = 1'b0;
      if (k == last_k + 1)
        check(mem_ce_n && mem_oe_n, "R7 deselect after last word",
              {30'd0, mem_ce_n, mem_oe_n}, 32'h3);
      if (k > last_k + G)
        check(mem_ce_n && !busy, "R8 ignored request leaves device idle",
              {30'd0, mem_ce_n, busy}, 32'h2);
      begin
        int rel;
        logic exp_v;
        rel = k - F - 1;
        exp_v = (rel >= 0) && (rel % P == 0) && (rel / P < n);
        if (rd_valid != exp_v) vbad++;
        if (exp_v) begin
          logic [AW-1:0] wa;
          int i;
          i = rel / P;
          wa = {a[AW-1:4], (a[3:0] & ~m) | ((a[3:0] + 4'(i)) & m)};
          check(rd_data == pat(wa), "R6 R3 word data", 32'(rd_data), 32'(pat(wa)));
          check(rd_last == (i == n - 1), "R2 last flag", 32'(rd_last), 32'(i == n - 1));
        end
      end
    end
    check(vbad == 0, "R4 R5 R2 valid schedule mismatches", 32'(vbad), 32'd0);
  endtask

  localparam logic [21:0] VECS [0:7] = '{
    {20'h00000, 2'd0}, {20'h12346, 2'd0}, {20'hABCD5, 2'd1}, {20'h5555F, 2'd2},
    {20'hFFFFC, 2'd2}, {20'h00007, 2'd1}, {20'h3C3C9, 2'd3}, {20'h80001, 2'd0}
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy && !rd_valid && mem_ce_n && mem_oe_n && mem_ub_n && mem_lb_n,
          "R1 state under reset", {26'd0, busy, rd_valid, mem_ce_n, mem_oe_n, mem_ub_n, mem_lb_n},
          32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !rd_valid && mem_ce_n, "R1 state after reset",
          {29'd0, busy, rd_valid, mem_ce_n}, 32'h1);

    // vector table: address, length code
    for (int v = 0; v < 8; v++) do_burst(VECS[v][21:2], VECS[v][1:0], 1'b0);

    // R8: request held through burst and gap is taken once only
    do_burst(20'h4A4A2, 2'd1, 1'b1);

    // back-to-back requests: second burst still returns correct data (R8 gap, R2 length)
    do_burst(20'h7777E, 2'd2, 1'b0);
    do_burst(20'h7777E, 2'd0, 1'b0);

    // R1: reset in the middle of a burst
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_addr = 20'h11111; req_len = 2'd2;
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!busy && !rd_valid && mem_ce_n && mem_oe_n, "R1 reset abandons burst",
          {28'd0, busy, rd_valid, mem_ce_n, mem_oe_n}, 32'h3);
    @(negedge clk); rst_n = 1'b1;
    do_burst(20'h0F0F3, 2'd0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule